// File: doc/BRIEF.md
# Sector Hamming ECC Generator and Corrector

This block produces a single-error-correcting Hamming code for a sector of bytes as they stream past. It also uses the same stream to check data that is being read back from storage. Every accepted byte adds to two 12-bit parity halves. Each data bit has a 12-bit location, made of its byte offset (9 bits) and its bit index (3 bits). The upper half collects the parity of the bits whose location has a given bit set. The lower half collects the parity of the bits whose location has that bit clear. The two halves are joined into a 24-bit word. The word is then bit-inverted, so that an erased sector (every byte 0xFF) produces the code 0xFFFFFF and checks clean.

On the write path the user reads `code_out` when `code_valid` pulses and stores its three bytes, least significant byte first. On the read path the user presents the stored code on `stored_code` and streams the sector back. When the stream ends, the block XORs the stored code with the fresh code and classifies the difference.

When the difference shows a single flipped data bit, the block repairs that byte itself. It reads the byte from a byte-wide sector buffer, flips the bit and writes the byte back.

Top module: `sector_hamming_ecc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `code_valid`, `done`, `buf_rd_en` and `buf_wr_en` are low.
- R2: `code_out` equals the bit-inverse of {U, L}, with U in bits 23:12 and L in bits 11:0.
  - Give each data bit the 12-bit location {byte offset[8:0], bit index[2:0]}.
  - U bit k is the XOR of all data bits whose location bit k is 1.
  - L bit k is the XOR of all data bits whose location bit k is 0.
  - Byte 0 of the stored code is `code_out[7:0]`.
  - An all-0xFF sector gives 0xFFFFFF.
- R3: Only cycles with `in_valid` high accept a byte. `code_valid` and `done` pulse for exactly one cycle, in the cycle after the edge that accepts the last byte of the sector. Idle cycles inside the stream do not change this timing.
- R4: `sec_start` discards any partial sector. A byte presented in the same cycle as `sec_start` becomes byte 0 of the new sector.
- R5: Once a full sector has been accepted, further bytes are ignored until the next `sec_start`. They do not change `code_out` and do not cause another `done`.
- R6: If `stored_code` equals the fresh code, `status` is 00 in the `done` cycle and the buffer is not touched.
- R7: Let D = `stored_code` XOR the fresh code. If D[11:0] XOR D[23:12] is 0xFFF and D[23:15] is below SECTOR_BYTES, then `status` is 01, `err_offset` is D[23:15] and `err_bit` is D[14:12] in the `done` cycle.
- R8: After a status of 01, the byte is repaired in three steps:
  - In the `done` cycle, `buf_rd_en` is high and `buf_addr` equals `err_offset`.
  - The buffer returns the byte on `buf_rd_data` in the next cycle.
  - One cycle after that, `buf_wr_en` is high and `buf_wr_data` is the returned byte with bit `err_bit` inverted.
- R9: If D has exactly one bit set, `status` is 10 (error in the stored code only) and the buffer is not touched.
- R10: Any other non-zero D gives `status` 11 (uncorrectable) and the buffer is not touched.
- R11: A D that matches the data-bit pattern but points to a byte offset at or beyond SECTOR_BYTES gives `status` 11 and the buffer is not touched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised on release |
| sec_start | input | 1 | Starts a new sector and clears the parity state |
| in_valid | input | 1 | `in_byte` carries a sector byte this cycle |
| in_byte | input | 8 | Sector data byte |
| stored_code | input | 24 | Code read from storage, held until the `done` cycle |
| code_valid | output | 1 | One-cycle pulse: `code_out` covers a complete sector |
| code_out | output | 24 | Inverted, packed parity code |
| done | output | 1 | One-cycle pulse: `status` and the error location are valid |
| status | output | 2 | 00 clean, 01 data bit corrected, 10 code-only error, 11 uncorrectable |
| err_offset | output | 9 | Byte offset of the flipped bit when status is 01, else 0 |
| err_bit | output | 3 | Bit index of the flipped bit when status is 01, else 0 |
| buf_rd_en | output | 1 | Read request to the sector buffer |
| buf_wr_en | output | 1 | Write request to the sector buffer |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_data | input | 8 | Byte returned by the buffer one cycle after `buf_rd_en` |
| buf_wr_data | output | 8 | Repaired byte |

## Verification
The data patterns are an erased sector, all-zero bytes, a ramp and a pseudo-random fill. The erased and zero sectors pin down the inversion and the all-0xFF corner. The ramp and random fills expose any swapped location bit or half.

Single-bit corruptions are placed at the first byte, the last byte and a byte in the middle. Together they tell apart each address and bit-index field, and they confirm the read-modify-write sequence. A flipped code bit at either end of the code word, and a pair of flipped data bits, separate the code-only class from the uncorrectable class.

A second instance with a half-size sector makes an out-of-range offset reachable. Restarted sectors, gapped streams and overrun bytes check the counting.

// File: rtl/ham_ecc_pkg.sv
package ham_ecc_pkg;
  localparam int HALF_W = 12;
  localparam int CODE_W = 2 * HALF_W;
  localparam int OFFS_W = 9;
  localparam int BIDX_W = 3;

  typedef enum logic [1:0] {
    ST_CLEAN     = 2'b00,
    ST_DATA_FIX  = 2'b01,
    ST_CODE_ONLY = 2'b10,
    ST_FATAL     = 2'b11
  } ecc_status_e;
endpackage

// File: rtl/ham_parity_acc.sv
module ham_parity_acc
  import ham_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_start,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic [HALF_W-1:0] hi_par,
  output logic [HALF_W-1:0] lo_par,
  output logic              sector_full
);
  localparam int CNT_W = $clog2(SECTOR_BYTES + 1);
  localparam logic [CNT_W-1:0] SEC_N    = CNT_W'(SECTOR_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SECTOR_BYTES - 1);

  function automatic logic [7:0] col_mask(input int j);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> j) & 1) == 1;
    return m;
  endfunction

  logic [CNT_W-1:0]  cnt_q, cnt_d, base_cnt;
  logic [HALF_W-1:0] hi_q, lo_q, hi_d, lo_d, base_hi, base_lo;
  logic              fin_q, fin_d;
  logic              accept, row_par, acc_en;
  logic [OFFS_W-1:0] offs;
  logic [BIDX_W-1:0] col_hi, col_lo;
  logic [HALF_W-1:0] add_hi, add_lo;

  assign row_par = ^in_byte;

  for (genvar j = 0; j < BIDX_W; j++) begin : g_col
    assign col_hi[j] = ^(in_byte & col_mask(j));
    assign col_lo[j] = row_par ^ col_hi[j];
  end

  always_comb begin
    base_cnt = sec_start ? '0 : cnt_q;
    base_hi  = sec_start ? '0 : hi_q;
    base_lo  = sec_start ? '0 : lo_q;
    accept   = in_valid && (base_cnt < SEC_N);
    offs     = OFFS_W'(base_cnt);
    add_hi   = {offs & {OFFS_W{row_par}}, col_hi};
    add_lo   = {~offs & {OFFS_W{row_par}}, col_lo};
    cnt_d    = accept ? base_cnt + 1'b1 : base_cnt;
    hi_d     = accept ? (base_hi ^ add_hi) : base_hi;
    lo_d     = accept ? (base_lo ^ add_lo) : base_lo;
    fin_d    = accept && (base_cnt == LAST_IDX);
    acc_en   = sec_start || accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= fin_d;
      if (acc_en) begin
        cnt_q <= cnt_d;
        hi_q  <= hi_d;
        lo_q  <= lo_d;
      end
    end
  end

  assign hi_par      = hi_q;
  assign lo_par      = lo_q;
  assign sector_full = fin_q;

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SEC_N);

  // R3
  full_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sector_full |-> $past(in_valid));

  // R3
  full_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_full && !sec_start) |=> !sector_full);
endmodule

// File: rtl/ham_syndrome_class.sv
module ham_syndrome_class
  import ham_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] stored_code,
  output ecc_status_e       status,
  output logic [OFFS_W-1:0] err_offset,
  output logic [BIDX_W-1:0] err_bit
);
  localparam logic [OFFS_W:0] LIMIT = (OFFS_W + 1)'(SECTOR_BYTES);

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] fold;
  logic [OFFS_W-1:0] loc_offs;
  logic [BIDX_W-1:0] loc_bit;
  logic              one_hot, data_pat, in_range;

  always_comb begin
    diff     = calc_code ^ stored_code;
    fold     = diff[HALF_W-1:0] ^ diff[CODE_W-1:HALF_W];
    loc_offs = diff[CODE_W-1:CODE_W-OFFS_W];
    loc_bit  = diff[HALF_W+BIDX_W-1:HALF_W];
    data_pat = (fold == {HALF_W{1'b1}});
    in_range = ({1'b0, loc_offs} < LIMIT);
    one_hot  = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
    err_offset = '0;
    err_bit    = '0;
    if (diff == '0) begin
      status = ST_CLEAN;
    end else if (data_pat) begin
      if (in_range) begin
        status     = ST_DATA_FIX;
        err_offset = loc_offs;
        err_bit    = loc_bit;
      end else begin
        status = ST_FATAL;
      end
    end else if (one_hot) begin
      status = ST_CODE_ONLY;
    end else begin
      status = ST_FATAL;
    end
  end
endmodule

// File: rtl/ham_bit_fixer.sv
module ham_bit_fixer
  import ham_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fix_req,
  input  logic [OFFS_W-1:0] fix_offset,
  input  logic [BIDX_W-1:0] fix_bit,
  input  logic [7:0]        buf_rd_data,
  output logic              buf_rd_en,
  output logic              buf_wr_en,
  output logic [OFFS_W-1:0] buf_addr,
  output logic [7:0]        buf_wr_data
);
  typedef enum logic [1:0] {FX_IDLE, FX_FETCH, FX_STORE} fix_state_e;

  fix_state_e        state_q, state_d;
  logic [OFFS_W-1:0] addr_q, addr_d;
  logic [7:0]        mask_q, mask_d, wdata_q, wdata_d;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    mask_d    = mask_q;
    wdata_d   = wdata_q;
    buf_rd_en = 1'b0;
    buf_wr_en = 1'b0;
    buf_addr  = addr_q;
    unique case (state_q)
      FX_IDLE: begin
        if (fix_req) begin
          buf_rd_en = 1'b1;
          buf_addr  = fix_offset;
          addr_d    = fix_offset;
          mask_d    = 8'h01 << fix_bit;
          state_d   = FX_FETCH;
        end
      end
      FX_FETCH: begin
        wdata_d = buf_rd_data ^ mask_q;
        state_d = FX_STORE;
      end
      FX_STORE: begin
        buf_wr_en = 1'b1;
        state_d   = FX_IDLE;
      end
      default: state_d = FX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FX_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      mask_q  <= mask_d;
      wdata_q <= wdata_d;
    end
  end

  assign buf_wr_data = wdata_q;

  // R8
  rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ($past(buf_rd_en, 2) && $past(buf_addr, 2) == buf_addr));

  // R8
  one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ($countones(buf_wr_data ^ $past(buf_rd_data)) == 1));
endmodule

// File: rtl/sector_hamming_ecc.sv
module sector_hamming_ecc
  import ham_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_start,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic [23:0] stored_code,
  output logic        code_valid,
  output logic [23:0] code_out,
  output logic        done,
  output logic [1:0]  status,
  output logic [8:0]  err_offset,
  output logic [2:0]  err_bit,
  output logic        buf_rd_en,
  output logic        buf_wr_en,
  output logic [8:0]  buf_addr,
  input  logic [7:0]  buf_rd_data,
  output logic [7:0]  buf_wr_data
);
  logic [HALF_W-1:0] hi_par, lo_par;
  logic              full;
  ecc_status_e       cls;
  logic              fix_req;

  ham_parity_acc #(.SECTOR_BYTES(SECTOR_BYTES)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_start   (sec_start),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .hi_par      (hi_par),
    .lo_par      (lo_par),
    .sector_full (full)
  );

  assign code_out   = ~{hi_par, lo_par};
  assign code_valid = full;
  assign done       = full;

  ham_syndrome_class #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .calc_code   (code_out),
    .stored_code (stored_code),
    .status      (cls),
    .err_offset  (err_offset),
    .err_bit     (err_bit)
  );

  assign status  = cls;
  assign fix_req = full && (cls == ST_DATA_FIX);

  ham_bit_fixer u_fix (
    .clk         (clk),
    .rst_n       (rst_n),
    .fix_req     (fix_req),
    .fix_offset  (err_offset),
    .fix_bit     (err_bit),
    .buf_rd_data (buf_rd_data),
    .buf_rd_en   (buf_rd_en),
    .buf_wr_en   (buf_wr_en),
    .buf_addr    (buf_addr),
    .buf_wr_data (buf_wr_data)
  );

  // R6
  clean_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b00) |-> (code_out == stored_code));

  // R7
  data_fix_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b01) |-> ($countones(code_out ^ stored_code) == 12));

  // R9
  code_only_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b10) |-> ($countones(code_out ^ stored_code) == 1));

  // R8
  rd_only_on_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |-> (done && status == 2'b01 && buf_addr == err_offset));
endmodule

// File: tb/tb_sector_hamming_ecc.sv
module tb_sector_hamming_ecc;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, sec_start, in_valid;
  logic [7:0]  in_byte;
  logic [23:0] stored_code;
  logic        code_valid, done, buf_rd_en, buf_wr_en;
  logic [23:0] code_out;
  logic [1:0]  status;
  logic [8:0]  err_offset, buf_addr;
  logic [2:0]  err_bit;
  logic [7:0]  buf_rd_data, buf_wr_data;

  logic        s_code_valid, s_done, s_buf_rd_en, s_buf_wr_en;
  logic [23:0] s_code_out;
  logic [1:0]  s_status;
  logic [8:0]  s_err_offset, s_buf_addr;
  logic [2:0]  s_err_bit;
  logic [7:0]  s_buf_rd_data, s_buf_wr_data;

  sector_hamming_ecc dut (
    .clk(clk), .rst_n(rst_n), .sec_start(sec_start), .in_valid(in_valid),
    .in_byte(in_byte), .stored_code(stored_code), .code_valid(code_valid),
    .code_out(code_out), .done(done), .status(status), .err_offset(err_offset),
    .err_bit(err_bit), .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
    .buf_addr(buf_addr), .buf_rd_data(buf_rd_data), .buf_wr_data(buf_wr_data));

  sector_hamming_ecc #(.SECTOR_BYTES(256)) dut_short (
    .clk(clk), .rst_n(rst_n), .sec_start(sec_start), .in_valid(in_valid),
    .in_byte(in_byte), .stored_code(stored_code), .code_valid(s_code_valid),
    .code_out(s_code_out), .done(s_done), .status(s_status),
    .err_offset(s_err_offset), .err_bit(s_err_bit), .buf_rd_en(s_buf_rd_en),
    .buf_wr_en(s_buf_wr_en), .buf_addr(s_buf_addr),
    .buf_rd_data(s_buf_rd_data), .buf_wr_data(s_buf_wr_data));

  assign s_buf_rd_data = 8'h00;

  logic [7:0] data_q [0:511];
  logic [7:0] mem    [0:511];
  int n_chk, n_bad, rd_cnt, wr_cnt, s_rd_cnt;
  bit early;
  logic        c_done, c_rd_en;
  logic [1:0]  c_status;
  logic [8:0]  c_off, c_addr;
  logic [2:0]  c_bit;
  logic [23:0] c_code;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (buf_rd_en) buf_rd_data <= mem[buf_addr];
    if (buf_wr_en) mem[buf_addr] <= buf_wr_data;
  end

  always @(negedge clk) begin
    if (buf_rd_en) rd_cnt++;
    if (buf_wr_en) wr_cnt++;
    if (s_buf_rd_en) s_rd_cnt++;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] model_code(input int n);
    logic [11:0] x;
    logic        p;
    x = '0;
    p = 1'b0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++)
        if (data_q[i][j]) begin
          x = x ^ {i[8:0], j[2:0]};
          p = ~p;
        end
    return ~{x, x ^ {12{p}}};
  endfunction

  task automatic load_pattern(input int kind);
    int s;
    s = 32'h1234_5678;
    for (int i = 0; i < 512; i++) begin
      case (kind)
        0: data_q[i] = 8'hFF;
        1: data_q[i] = 8'h00;
        2: data_q[i] = 8'(i * 7 + 3);
        default: begin
          s = s * 1103515245 + 12345;
          data_q[i] = s[23:16];
        end
      endcase
      mem[i] = data_q[i];
    end
  endtask

  task automatic stream(input int n, input bit gaps);
    early = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk);
        if (done) early = 1'b1;
        sec_start = 1'b0;
        in_valid  = 1'b0;
      end
      @(negedge clk);
      if (done && i > 0) early = 1'b1;
      sec_start = (i == 0);
      in_valid  = 1'b1;
      in_byte   = data_q[i];
    end
    @(negedge clk);
    c_done   = done;
    c_status = status;
    c_off    = err_offset;
    c_bit    = err_bit;
    c_code   = code_out;
    c_rd_en  = buf_rd_en;
    c_addr   = buf_addr;
    sec_start = 1'b0;
    in_valid  = 1'b0;
  endtask

  task automatic expect_no_access(input string req, input int rd0, input int wr0);
    repeat (3) @(negedge clk);
    chk(rd_cnt == rd0 && wr_cnt == wr0, req, "buffer touched",
        32'(rd_cnt - rd0), 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sec_start = 1'b0; in_valid = 1'b0; in_byte = '0;
    stored_code = '0;
    repeat (3) @(negedge clk);
    chk(!code_valid && !done && !buf_rd_en && !buf_wr_en, "R1", "outputs in reset",
        {code_valid, done, buf_rd_en, buf_wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!code_valid && !done && !buf_rd_en && !buf_wr_en, "R1", "outputs after reset",
        {code_valid, done, buf_rd_en, buf_wr_en}, 0);
  endtask

  task automatic t_clean(input int kind, input bit gaps);
    int rd0, wr0;
    load_pattern(kind);
    stored_code = model_code(512);
    rd0 = rd_cnt; wr0 = wr_cnt;
    stream(512, gaps);
    chk(c_done && !early, "R3", "done timing", {early, c_done}, 1);
    chk(c_code == stored_code, "R2", "code value", c_code, stored_code);
    if (kind == 0) chk(c_code == 24'hFFFFFF, "R2", "erased code", c_code, 24'hFFFFFF);
    chk(c_status == 2'b00, "R6", "clean status", c_status, 0);
    @(negedge clk);
    chk(!done && !code_valid, "R3", "done is one pulse", done, 0);
    expect_no_access("R6", rd0, wr0);
  endtask

  task automatic t_restart();
    load_pattern(3);
    stream(100, 1'b0);
    load_pattern(2);
    stored_code = model_code(512);
    stream(512, 1'b0);
    chk(c_done && c_code == stored_code, "R4", "code after restart", c_code, stored_code);
  endtask

  task automatic t_overrun();
    logic [23:0] exp;
    bit extra_done;
    load_pattern(3);
    exp = model_code(512);
    stored_code = exp;
    stream(512, 1'b0);
    extra_done = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (done) extra_done = 1'b1;
      in_valid = 1'b1;
      in_byte  = 8'(8'h5A + i);
    end
    @(negedge clk);
    if (done) extra_done = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    if (done) extra_done = 1'b1;
    chk(code_out == exp, "R5", "code after extra bytes", code_out, exp);
    chk(!extra_done, "R5", "done after extra bytes", extra_done, 0);
  endtask

  task automatic t_fix(input int off, input int bt);
    logic [7:0] good;
    load_pattern(3);
    stored_code = model_code(512);
    good = data_q[off];
    data_q[off][bt] = ~data_q[off][bt];
    mem[off] = data_q[off];
    stream(512, 1'b0);
    chk(c_status == 2'b01, "R7", "fix status", c_status, 2'b01);
    chk(c_off == 9'(off) && c_bit == 3'(bt), "R7", "location",
        {c_off, c_bit}, {9'(off), 3'(bt)});
    chk(c_rd_en && c_addr == 9'(off), "R8", "read request", {c_rd_en, c_addr}, {1'b1, 9'(off)});
    @(negedge clk);
    chk(!buf_wr_en, "R8", "no early write", buf_wr_en, 0);
    @(negedge clk);
    chk(buf_wr_en && buf_addr == 9'(off) && buf_wr_data == good, "R8", "write back",
        {buf_wr_en, buf_addr, buf_wr_data}, {1'b1, 9'(off), good});
    @(negedge clk);
    chk(mem[off] == good, "R8", "buffer repaired", mem[off], good);
  endtask

  task automatic t_code_only(input int k);
    int rd0, wr0;
    load_pattern(2);
    stored_code = model_code(512) ^ (24'h1 << k);
    rd0 = rd_cnt; wr0 = wr_cnt;
    stream(512, 1'b0);
    chk(c_done && c_status == 2'b10, "R9", "code-only status", c_status, 2'b10);
    expect_no_access("R9", rd0, wr0);
  endtask

  task automatic t_double();
    int rd0, wr0;
    load_pattern(3);
    stored_code = model_code(512);
    data_q[10][1] = ~data_q[10][1];
    data_q[20][6] = ~data_q[20][6];
    mem[10] = data_q[10];
    mem[20] = data_q[20];
    rd0 = rd_cnt; wr0 = wr_cnt;
    stream(512, 1'b0);
    chk(c_done && c_status == 2'b11, "R10", "double error status", c_status, 2'b11);
    expect_no_access("R10", rd0, wr0);
    chk(mem[10] == data_q[10] && mem[20] == data_q[20], "R10", "buffer unchanged",
        mem[10], data_q[10]);
  endtask

  task automatic t_out_of_range();
    logic [11:0] loc;
    logic [23:0] exp;
    int s0;
    load_pattern(2);
    exp = model_code(256);
    loc = {9'd300, 3'd2};
    stored_code = exp ^ {loc, ~loc};
    s0 = s_rd_cnt;
    early = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      sec_start = (i == 0);
      in_valid  = 1'b1;
      in_byte   = data_q[i];
    end
    @(negedge clk);
    sec_start = 1'b0;
    in_valid  = 1'b0;
    chk(s_done && s_code_out == exp, "R2", "short sector code", s_code_out, exp);
    chk(s_status == 2'b11, "R11", "offset beyond sector", s_status, 2'b11);
    repeat (3) @(negedge clk);
    chk(s_rd_cnt == s0 && !s_buf_wr_en, "R11", "buffer touched", s_rd_cnt - s0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL R3 watchdog expired act=%0d exp=%0d", n_chk, 0);
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; rd_cnt = 0; wr_cnt = 0; s_rd_cnt = 0;
    buf_rd_data = '0;
    t_reset();
    t_clean(0, 1'b0);
    t_clean(1, 1'b0);
    t_clean(2, 1'b1);
    t_clean(3, 1'b0);
    t_restart();
    t_overrun();
    t_fix(0, 0);
    t_fix(511, 7);
    t_fix(300, 5);
    t_code_only(0);
    t_code_only(23);
    t_double();
    t_out_of_range();
    summary();
    $finish;
  end
endmodule